// File: doc/BRIEF.md
# Serial-Load DAC Input Register

This block is the digital front end of a 16-bit serial-input converter. A host drives three plain control pins: an active-low select, a serial clock and a serial data line. While the select is low, each rising edge of the serial clock moves one data bit into a shift register, most significant bit first. When the select returns high, the shift register contents are copied into a parallel holding register whose value is the block's output code.

All three serial pins are oversampled by the block's own clock through a synchronizer of `SYNC_STAGES` flops. Edges are then found by comparing each synchronized level with its value one cycle earlier. Each phase of the serial clock, and the select's high and low times, must last at least two cycles of `clk`.

The output side is a stream with a valid strobe and no ready. `upd_valid` is high for exactly one `clk` cycle on each transfer. The consumer has no way to apply back-pressure and must take `dac_word` in that cycle or read it later, because the word stays constant until the next transfer.

Top module: `sdac_serial_load`

## Requirements
- R1: While `rst_n` is low, `dac_word` reads 0x0000 and `upd_valid` reads 0. The shift register also clears to zero, so a frame with no serial clock edges sent after reset loads 0x0000.
- R2: While the select is low, a rising serial clock edge samples `sdi` into bit 0 and moves the older bits up by one place. A 16-edge frame therefore loads its first bit into bit 15 and its last bit into bit 0.
- R3: A frame with more than 16 serial clock edges keeps only the last 16 bits sent. Every earlier bit is lost.
- R4: The holding register changes only when the select rises, and it keeps its value in every other cycle.
- R5: The shift register is not cleared between frames. A frame of k bits with k < 16 loads the previous shift contents moved up by k places, with the k new bits in the low positions. A frame with no serial clock edges reloads the previous contents unchanged and still raises the strobe.
- R6: Serial clock edges while the select is high leave the shift register, `dac_word` and `upd_valid` unchanged.
- R7: `upd_valid` is high for exactly one `clk` cycle per rising edge of the select. There is no ready input.
- R8: After the select rises at the pin, `upd_valid` and the new `dac_word` become visible after the (`SYNC_STAGES`+1)-th rising edge of `clk`. With the default parameters this is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select; its rising edge transfers the word |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| dac_word | output | WIDTH | Holding register value (output code) |
| upd_valid | output | 1 | One-cycle strobe marking a new `dac_word` |

## Verification
The bound checker tests the cycle-level rules on every cycle:
- each shift step takes the synchronized data bit into bit 0;
- the shift register stays frozen while the select is high;
- a transfer copies the shift register value from the cycle before;
- `dac_word` holds in every cycle without a strobe;
- the strobe never lasts more than one cycle.

Some results depend on the history of whole frames, and only the bench scenarios show them:
- which 16 bits survive a long frame;
- the merged value left by a short frame or an empty frame;
- that clocks sent between frames have no effect;
- the exact latency from the select pin to the output.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Bundle of the three serial pins as they travel through the synchronizer
  typedef struct packed {
    logic sel_n;
    logic sck;
    logic sd;
  } sdac_pins_t;

  // Idle levels: select deasserted, clock low, data low
  localparam sdac_pins_t PINS_IDLE = '{sel_n: 1'b1, sck: 1'b0, sd: 1'b0};
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync
  import sdac_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sdac_pins_t pins_in,
  output sdac_pins_t pins_lvl
);
  localparam int LAST = STAGES - 1;

  sdac_pins_t chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= PINS_IDLE;
          else        chain[g] <= pins_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= PINS_IDLE;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign pins_lvl = chain[LAST];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_lvl,
  input  logic sel_lvl,
  output logic sck_rise,
  output logic sel_rise
);
  logic sck_prev;
  logic sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      sel_prev <= 1'b1;
    end else begin
      sck_prev <= sck_lvl;
      sel_prev <= sel_lvl;
    end
  end

  assign sck_rise = sck_lvl & ~sck_prev;
  assign sel_rise = sel_lvl & ~sel_prev;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (step) word <= {word[WIDTH-2:0], bit_in};
  end
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_out,
  output logic             strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out <= '0;
      strobe   <= 1'b0;
    end else begin
      strobe <= load;
      if (load) word_out <= word_in;
    end
  end
endmodule

// File: rtl/sdac_serial_load.sv
module sdac_serial_load
  import sdac_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic [WIDTH-1:0] dac_word,
  output logic             upd_valid
);
  sdac_pins_t       pins_raw;
  sdac_pins_t       pins_lvl;
  logic             csn_lvl;
  logic             sdata_lvl;
  logic             sclk_rise;
  logic             csn_rise;
  logic             shift_en;
  logic [WIDTH-1:0] shift_q;

  assign pins_raw = '{sel_n: cs_n, sck: sclk, sd: sdi};

  sdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_in  (pins_raw),
    .pins_lvl (pins_lvl)
  );

  assign csn_lvl   = pins_lvl.sel_n;
  assign sdata_lvl = pins_lvl.sd;

  sdac_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_lvl  (pins_lvl.sck),
    .sel_lvl  (csn_lvl),
    .sck_rise (sclk_rise),
    .sel_rise (csn_rise)
  );

  // shifting is allowed only while the frame select is held low
  assign shift_en = sclk_rise & ~csn_lvl;

  sdac_shift #(.WIDTH(WIDTH)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (shift_en),
    .bit_in (sdata_lvl),
    .word   (shift_q)
  );

  sdac_hold #(.WIDTH(WIDTH)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (csn_rise),
    .word_in  (shift_q),
    .word_out (dac_word),
    .strobe   (upd_valid)
  );
endmodule

// File: rtl/sdac_serial_load_chk.sv
module sdac_serial_load_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csn_lvl,
  input logic             sclk_rise,
  input logic             sdata_lvl,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] dac_word,
  input logic             upd_valid
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (dac_word == '0 && !upd_valid); // R1
  end

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !csn_lvl) |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(sdata_lvl)}); // R2

  AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> dac_word == $past(shift_q)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> $stable(dac_word)); // R4

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    csn_lvl |=> $stable(shift_q)); // R6

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid); // R7
endmodule

bind sdac_serial_load sdac_serial_load_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csn_lvl   (csn_lvl),
  .sclk_rise (sclk_rise),
  .sdata_lvl (sdata_lvl),
  .shift_q   (shift_q),
  .dac_word  (dac_word),
  .upd_valid (upd_valid)
);

// File: tb/test_sdac_serial_load.sv
`timescale 1ns/1ps
module test_sdac_serial_load;
  localparam int WIDTH = 16;
  localparam int SYNC  = 2;
  localparam int HALF  = 3; // clk cycles per serial clock phase

  // {bit count, frame data, expected word}
  localparam logic [53:0] VEC [9] = '{
    {6'd16, 32'h0000_A5C3, 16'hA5C3},  // R2
    {6'd16, 32'h0000_FFFF, 16'hFFFF},  // R2
    {6'd16, 32'h0000_0000, 16'h0000},  // R2
    {6'd20, 32'h0009_1234, 16'h1234},  // R3
    {6'd24, 32'h00AB_CDEF, 16'hCDEF},  // R3
    {6'd8,  32'h0000_005A, 16'hEF5A},  // R5
    {6'd4,  32'h0000_0003, 16'hF5A3},  // R5
    {6'd0,  32'h0000_0000, 16'hF5A3},  // R5 empty frame
    {6'd16, 32'h0000_8001, 16'h8001}   // R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [WIDTH-1:0] dac_word;
  logic upd_valid;

  int n_checks = 0;
  int n_fail = 0;
  int n_strobes = 0;
  logic done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sdac_serial_load #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC)) i_sdac_serial_load (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dac_word(dac_word), .upd_valid(upd_valid)
  );

  always @(negedge clk) if (upd_valid) n_strobes++;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame and checks the transfer timing and value
  task automatic send_frame(input int nbits, input logic [31:0] data,
                            input logic [15:0] exp, input string req);
    @(negedge clk);
    cs_n = 1'b0;
    wait_neg(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = data[i];
      sclk = 1'b0;
      wait_neg(HALF);
      sclk = 1'b1;
      wait_neg(HALF);
    end
    sclk = 1'b0;
    wait_neg(HALF);
    cs_n = 1'b1;
    repeat (SYNC) @(posedge clk);
    #1;
    check(upd_valid == 1'b0, "R8 early", 32'(upd_valid), 32'd0);
    @(posedge clk);
    #1;
    check(upd_valid == 1'b1, "R8/R7 strobe", 32'(upd_valid), 32'd1);
    check(dac_word == exp, req, 32'(dac_word), 32'(exp));
    @(posedge clk);
    #1;
    check(upd_valid == 1'b0, "R7 one cycle", 32'(upd_valid), 32'd0);
    wait_neg(4);
    check(dac_word == exp, "R4 hold", 32'(dac_word), 32'(exp));
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int s0;
    wait_neg(3);
    check(dac_word == 16'h0 && upd_valid == 1'b0, "R1 reset",
          {15'd0, upd_valid, dac_word}, 32'd0);
    rst_n = 1'b1;
    wait_neg(4);

    for (int k = 0; k < 9; k++)
      send_frame(int'(VEC[k][53:48]), VEC[k][47:16], VEC[k][15:0], "R2/R3/R5 word");

    // R6: serial clock edges while the select is high
    s0 = n_strobes;
    for (int i = 0; i < 8; i++) begin
      sdi = 1'b1;
      sclk = 1'b1;
      wait_neg(HALF);
      sclk = 1'b0;
      wait_neg(HALF);
    end
    sdi = 1'b0;
    check(n_strobes == s0, "R6 no strobe", n_strobes, s0);
    check(dac_word == 16'h8001, "R6 word kept", 32'(dac_word), 32'h8001);
    send_frame(0, 32'h0, 16'h8001, "R6 shift untouched");

    // R1: reset mid-run clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    wait_neg(2);
    check(dac_word == 16'h0 && upd_valid == 1'b0, "R1 reset again",
          32'(dac_word), 32'd0);
    rst_n = 1'b1;
    wait_neg(4);
    send_frame(0, 32'h0, 16'h0000, "R1 shift cleared");

    // R3: long 32-bit frame keeps the final 16 bits
    send_frame(32, 32'hDEAD_3C96, 16'h3C96, "R3 long frame");
    s0 = n_strobes;
    wait_neg(10);
    check(n_strobes == s0, "R4 no spurious load", n_strobes, s0);

    finish_run();
  end
endmodule